// File: doc/BRIEF.md
# Queued CAM Interrupt Scheduler

This block stores pending interrupt requests and decides which one the processor is told to serve next. It has a small array of associative words. Each word owns one priority level while that level has pending or running work. Behind each word sits a short fixed-depth queue, so repeated requests on the same level wait their turn in arrival order instead of being lost. A request carries an 8-bit level, an 8-bit line number, a 4-bit source ID and the enable state of its line. It joins the queue of the word that already holds its level. If no word holds that level, it takes a free word.

The block always looks for the filled word with the largest value of the enable bit placed above the level. When that word is enabled and not yet running, it is offered on the notification output. Accepting the offer marks the word as running. When the processor reports that a level has completed, the word is released and the next queued request moves to the front. Its enable bit is then fetched through a lookup port from the external line table. Enable changes per line, a clear-by-line command and an overflow trap complete the interface.

New requests enter on a valid/ready stream. `req_ready` falls whenever a completion, clear or enable update is presented, because only one operation is applied per cycle. A request held with `req_valid` is taken on the first cycle `req_ready` is high. The notification is a valid/ready stream too. The offer always shows the current best candidate: if a higher enabled level arrives before the consumer accepts, the offer switches to that level. A word is marked running only on the `ntf_valid && ntf_ready` handshake. The completion, clear and enable inputs are plain one-cycle commands that are always taken.

Top module: `qcam_sched`

## Requirements
- R1: After reset no word is filled, `ntf_valid` and `ovf_trap` are 0, and `req_ready` is 1.
- R2: An accepted request whose level matches no filled word takes a vacant word, choosing the highest-indexed one. If it is enabled and the best candidate, it is offered with its level, line and source ID on the cycle after acceptance.
- R3: A request whose level matches a filled word joins the rear of that word's queue. Requests of one level are offered in arrival order. A request behind a running head raises no notification.
- R4: The offered word is the filled word with the largest {enable, level} value, with levels compared unsigned. Any enabled word outranks any disabled word. No offer is made when that word is disabled or already running.
- R5: A completion with a level that matches a filled word frees that word. The next queued entry takes its place with its enable bit taken from `promo_en`, which answers the line shown on `promo_line`. A waiting enabled lower level is then offered if it is the new best.
- R6: An enable update sets the enable bit of every stored entry, at the front or queued, whose line equals `en_line`. Enabling a pending level that becomes the best candidate raises an offer.
- R7: An accepted request whose level's queue already holds DEPTH entries, or which finds no vacant word, is dropped. `ovf_trap` is then 1 for the single cycle after acceptance.
- R8: A clear removes the front entry of every word whose front line equals `clr_line`, including several at once, and each affected queue moves forward. A cleared level no longer absorbs new requests of that level.
- R9: Only one operation applies per cycle, with priority completion > clear > enable update > request. `req_ready` is 0 while any of `cmp_valid`, `clr_valid`, `en_valid` is 1, and a held request is accepted afterwards.
- R10: While `ntf_ready` is 0 and nothing else changes, `ntf_valid` and the offered fields stay unchanged. Accepting an offer marks the word as running, so the same entry is not offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_level | input | 8 | Priority level of the request |
| req_line | input | 8 | Interrupt line number |
| req_sid | input | 4 | Source ID within the line |
| req_en | input | 1 | Enable state of the request's line |
| cmp_valid | input | 1 | Completion report present |
| cmp_level | input | 8 | Level whose routine completed |
| clr_valid | input | 1 | Clear-by-line command |
| clr_line | input | 8 | Line to clear |
| en_valid | input | 1 | Enable update command |
| en_line | input | 8 | Line whose enable changes |
| en_value | input | 1 | New enable value |
| promo_line | output | 8 | Line of the entry about to be promoted by a completion |
| promo_en | input | 1 | Enable bit for `promo_line` from the line table |
| ntf_valid | output | 1 | Service offer present |
| ntf_ready | input | 1 | Consumer accepts the offer |
| ntf_level | output | 8 | Offered level |
| ntf_line | output | 8 | Offered line |
| ntf_sid | output | 4 | Offered source ID |
| ovf_trap | output | 1 | One-cycle pulse: request dropped |

## Verification
The test provokes two kinds of same-cycle collision. In the first, a request is held on the stream while a completion is presented in the same cycle. The bench checks that `req_ready` is low in that cycle, that the completion takes effect, and that the request enters one cycle later and produces its own offer. In the second, the notification consumer holds `ntf_ready` low while a new enabled level is stored. The offer must stay steady across several cycles and be taken exactly once when ready rises. Every offer is compared by a scoreboard against an expected sequence built from the ordering rules.

// File: rtl/qcam_pkg.sv
package qcam_pkg;
  localparam int LVL_W  = 8;
  localparam int LINE_W = 8;
  localparam int SID_W  = 4;

  typedef struct packed {
    logic              f;
    logic              e;
    logic [LVL_W-1:0]  lvl;
    logic [LINE_W-1:0] line;
    logic [SID_W-1:0]  sid;
  } qent_t;
endpackage

// File: rtl/qcam_slot.sv
// One associative word (entry 0) with its queue (entries 1..DEPTH-1).
// DEPTH must be at least 2.
module qcam_slot
  import qcam_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  qent_t             push_ent,
  input  logic              pop,
  input  logic              pop_ext,
  input  logic              pop_e,
  input  logic              eupd,
  input  logic [LINE_W-1:0] eupd_line,
  input  logic              eupd_val,
  input  logic              run_set,
  output qent_t             head,
  output logic              run,
  output logic              full,
  output logic [LINE_W-1:0] next_line
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  qent_t          ent [DEPTH];
  qent_t          nxt [DEPTH];
  logic           run_q;
  logic [PW-1:0]  tail_pos;

  // first empty position; filled entries always form a prefix
  always_comb begin
    tail_pos = PW'(DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent[i].f) tail_pos = PW'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = ent[i];
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt[i] = ent[i+1];
      nxt[DEPTH-1] = '0;
      if (pop_ext && ent[1].f) nxt[0].e = pop_e;
    end else if (push && !ent[DEPTH-1].f) begin
      nxt[tail_pos]   = push_ent;
      nxt[tail_pos].f = 1'b1;
    end
    if (eupd) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (nxt[i].f && nxt[i].line == eupd_line) nxt[i].e = eupd_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      run_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
      if (pop)          run_q <= 1'b0;
      else if (run_set) run_q <= 1'b1;
    end
  end

  assign head      = ent[0];
  assign run       = run_q;
  assign full      = ent[DEPTH-1].f;
  assign next_line = ent[1].line;

  // R3: queue stays packed towards the front
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_pack
    a_r3_packed: assert property (@(posedge clk) disable iff (!rst_n)
      ent[i+1].f |-> ent[i].f);
  end

  // R2: a push into a slot always leaves a filled front
  a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> head.f);

  // R5: a released front is never left marked running
  a_r5_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !run);
endmodule

// File: rtl/qcam_pick.sv
// Associative searches across the front words.
module qcam_pick
  import qcam_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  qent_t             heads [WORDS],
  input  logic [LVL_W-1:0]  key_a,
  input  logic [LVL_W-1:0]  key_b,
  input  logic [LINE_W-1:0] clr_line,
  output logic              hit_a,
  output logic [IW-1:0]     idx_a,
  output logic              hit_b,
  output logic [IW-1:0]     idx_b,
  output logic              vac_any,
  output logic [IW-1:0]     vac_idx,
  output logic              best_any,
  output logic [IW-1:0]     best_idx,
  output logic [WORDS-1:0]  clr_mask
);
  logic [LVL_W:0] best_key;

  always_comb begin
    hit_a    = 1'b0;  idx_a    = '0;
    hit_b    = 1'b0;  idx_b    = '0;
    vac_any  = 1'b0;  vac_idx  = '0;
    best_any = 1'b0;  best_idx = '0;
    best_key = '0;
    clr_mask = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (heads[i].f) begin
        if (heads[i].lvl == key_a) begin hit_a = 1'b1; idx_a = IW'(i); end
        if (heads[i].lvl == key_b) begin hit_b = 1'b1; idx_b = IW'(i); end
        clr_mask[i] = (heads[i].line == clr_line);
        if (!best_any || {heads[i].e, heads[i].lvl} > best_key) begin
          best_any = 1'b1;
          best_idx = IW'(i);
          best_key = {heads[i].e, heads[i].lvl};
        end
      end else begin
        // later (higher) index overrides: highest vacant wins
        vac_any = 1'b1;
        vac_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/qcam_sched.sv
module qcam_sched
  import qcam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [LINE_W-1:0] req_line,
  input  logic [SID_W-1:0]  req_sid,
  input  logic              req_en,
  input  logic              cmp_valid,
  input  logic [LVL_W-1:0]  cmp_level,
  input  logic              clr_valid,
  input  logic [LINE_W-1:0] clr_line,
  input  logic              en_valid,
  input  logic [LINE_W-1:0] en_line,
  input  logic              en_value,
  output logic [LINE_W-1:0] promo_line,
  input  logic              promo_en,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [LVL_W-1:0]  ntf_level,
  output logic [LINE_W-1:0] ntf_line,
  output logic [SID_W-1:0]  ntf_sid,
  output logic              ovf_trap
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  qent_t             heads  [WORDS];
  logic [LINE_W-1:0] nlines [WORDS];
  logic [WORDS-1:0]  runs, fulls, clr_mask;
  logic              hit_a, hit_b, vac_any, best_any;
  logic [IW-1:0]     idx_a, idx_b, vac_idx, best_idx;
  logic              do_cmp, do_clr, do_en, do_req, ntf_acc;
  logic              req_full, ovf_q;
  qent_t             new_ent;

  // one operation per cycle, fixed priority
  assign do_cmp    = cmp_valid;
  assign do_clr    = clr_valid && !cmp_valid;
  assign do_en     = en_valid && !cmp_valid && !clr_valid;
  assign req_ready = !(cmp_valid || clr_valid || en_valid);
  assign do_req    = req_valid && req_ready;

  qcam_pick #(.WORDS(WORDS)) u_pick (
    .heads    (heads),
    .key_a    (req_level),
    .key_b    (cmp_level),
    .clr_line (clr_line),
    .hit_a    (hit_a),
    .idx_a    (idx_a),
    .hit_b    (hit_b),
    .idx_b    (idx_b),
    .vac_any  (vac_any),
    .vac_idx  (vac_idx),
    .best_any (best_any),
    .best_idx (best_idx),
    .clr_mask (clr_mask)
  );

  assign req_full = hit_a ? fulls[idx_a] : !vac_any;
  assign new_ent  = '{f: 1'b1, e: req_en, lvl: req_level, line: req_line, sid: req_sid};

  assign ntf_valid = best_any && heads[best_idx].e && !runs[best_idx];
  assign ntf_level = heads[best_idx].lvl;
  assign ntf_line  = heads[best_idx].line;
  assign ntf_sid   = heads[best_idx].sid;
  assign ntf_acc   = ntf_valid && ntf_ready;

  assign promo_line = hit_b ? nlines[idx_b] : '0;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic pop_g, push_g;
    assign pop_g  = (do_cmp && hit_b && idx_b == IW'(g)) || (do_clr && clr_mask[g]);
    assign push_g = do_req && !req_full &&
                    (hit_a ? (idx_a == IW'(g)) : (vac_idx == IW'(g)));

    qcam_slot #(.DEPTH(DEPTH)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_g),
      .push_ent  (new_ent),
      .pop       (pop_g),
      .pop_ext   (do_cmp),
      .pop_e     (promo_en),
      .eupd      (do_en),
      .eupd_line (en_line),
      .eupd_val  (en_value),
      .run_set   (ntf_acc && best_idx == IW'(g)),
      .head      (heads[g]),
      .run       (runs[g]),
      .full      (fulls[g]),
      .next_line (nlines[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= do_req && req_full;
  end
  assign ovf_trap = ovf_q;

  // R7: a trap only follows an accepted request
  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> $past(req_valid && req_ready));

  // R10: a held offer stays steady while nothing else happens
  a_r10_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready && !req_valid && !cmp_valid && !clr_valid && !en_valid)
    |=> (ntf_valid && $stable(ntf_line) && $stable(ntf_level) && $stable(ntf_sid)));

  // R10: an accepted offer is not repeated when nothing else changes
  a_r10_accept_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && ntf_ready && !req_valid && !cmp_valid && !clr_valid && !en_valid)
    |=> !ntf_valid);

  // R9: a completion blocks the request stream in its cycle
  a_r9_cmp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> !req_ready);
endmodule

// File: tb/qcam_sched_test.sv
module qcam_sched_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_en, cmp_valid, clr_valid, en_valid, en_value, ntf_ready;
  logic [7:0] req_level, req_line, cmp_level, clr_line, en_line;
  logic [3:0] req_sid;
  logic       req_ready, ntf_valid, ovf_trap, promo_en;
  logic [7:0] promo_line, ntf_level, ntf_line;
  logic [3:0] ntf_sid;
  logic       tbl [256];

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_P/2) clk = ~clk;
  assign promo_en = tbl[promo_line];

  qcam_sched uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_level(req_level),
    .req_line(req_line), .req_sid(req_sid), .req_en(req_en),
    .cmp_valid(cmp_valid), .cmp_level(cmp_level),
    .clr_valid(clr_valid), .clr_line(clr_line),
    .en_valid(en_valid), .en_line(en_line), .en_value(en_value),
    .promo_line(promo_line), .promo_en(promo_en),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_level(ntf_level),
    .ntf_line(ntf_line), .ntf_sid(ntf_sid), .ovf_trap(ovf_trap)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_ntf(input int l, input int n, input int s, input string tag);
    exp_q.push_back({l[7:0], n[7:0], s[3:0]});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the negedge just after the accepting edge
  task automatic send_req(input int l, input int n, input int s, input bit e);
    @(negedge clk);
    req_level = l[7:0]; req_line = n[7:0]; req_sid = s[3:0]; req_en = e;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_cmp(input int l);
    @(negedge clk); cmp_valid = 1'b1; cmp_level = l[7:0];
    @(negedge clk); cmp_valid = 1'b0;
    idle(2);
  endtask

  task automatic send_clr(input int n);
    @(negedge clk); clr_valid = 1'b1; clr_line = n[7:0];
    @(negedge clk); clr_valid = 1'b0;
    idle(2);
  endtask

  task automatic send_en(input int n, input bit v);
    @(negedge clk); en_valid = 1'b1; en_line = n[7:0]; en_value = v;
    @(negedge clk); en_valid = 1'b0;
    idle(2);
  endtask

  // monitor: compares every accepted offer with the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n === 1'b1 && ntf_valid && ntf_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected offer", {ntf_level, ntf_line, ntf_sid}, 0);
        end else begin
          logic [19:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({ntf_level, ntf_line, ntf_sid} == e, t, {ntf_level, ntf_line, ntf_sid}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tbl[i] = 1'b1;
    rst_n = 1'b0;
    req_valid = 0; req_en = 0; req_level = 0; req_line = 0; req_sid = 0;
    cmp_valid = 0; cmp_level = 0; clr_valid = 0; clr_line = 0;
    en_valid = 0; en_line = 0; en_value = 0; ntf_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1); #1;
    check(ntf_valid == 0, "R1 offer after reset", ntf_valid, 0);
    check(ovf_trap == 0, "R1 trap after reset", ovf_trap, 0);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R2 / R3 / R4 / R5 basic ordering
    expect_ntf(5, 10, 1, "R2 first request offered");
    send_req(5, 10, 1, 1); idle(2);
    send_req(5, 11, 2, 1); idle(2); #1;
    check(ntf_valid == 0, "R3 queued behind running", ntf_valid, 0);
    expect_ntf(9, 20, 3, "R2 higher level preempts");
    send_req(9, 20, 3, 1); idle(2);
    send_req(3, 30, 4, 1); idle(2); #1;
    check(ntf_valid == 0, "R4 lower level waits", ntf_valid, 0);
    send_cmp(9); #1;
    check(ntf_valid == 0, "R4 running level not re-offered", ntf_valid, 0);
    expect_ntf(5, 11, 2, "R3 same level in arrival order");
    send_cmp(5);
    expect_ntf(3, 30, 4, "R5 lower waiting level after completion");
    send_cmp(5);
    send_cmp(3); #1;
    check(ntf_valid == 0, "R5 empty after last completion", ntf_valid, 0);

    // R5 promotion enable from lookup, R6 enable update
    expect_ntf(7, 40, 5, "R2 level 7 offered");
    send_req(7, 40, 5, 1); idle(2);
    send_req(7, 41, 6, 1); idle(2);
    tbl[41] = 1'b0;
    send_cmp(7); #1;
    check(ntf_valid == 0, "R5 promoted entry takes disabled state", ntf_valid, 0);
    expect_ntf(7, 41, 6, "R6 enabling promoted line");
    send_en(41, 1'b1);
    send_cmp(7);

    // R4 disabled outranked, R6 enable raises pending level
    send_req(12, 50, 7, 0); idle(2); #1;
    check(ntf_valid == 0, "R4 disabled level not offered", ntf_valid, 0);
    expect_ntf(2, 51, 8, "R4 enabled low level beats disabled high");
    send_req(2, 51, 8, 1); idle(2);
    expect_ntf(12, 50, 7, "R6 enabled high pending level");
    send_en(50, 1'b1);
    send_cmp(12); #1;
    check(ntf_valid == 0, "R4 running lower level not re-offered", ntf_valid, 0);
    send_cmp(2);

    // R7 overflow: full queue, then no vacant word
    expect_ntf(4, 60, 0, "R2 level 4 offered");
    send_req(4, 60, 0, 1); idle(2);
    for (int k = 1; k < 4; k++) begin send_req(4, 60 + k, k, 1); idle(1); end
    send_req(4, 64, 4, 1); #1;
    check(ovf_trap == 1, "R7 trap on full queue", ovf_trap, 1);
    idle(1); #1;
    check(ovf_trap == 0, "R7 trap is one cycle", ovf_trap, 0);
    for (int k = 0; k < 7; k++) begin send_req(20 + k, 70 + k, k, 0); idle(1); end
    #1;
    check(ovf_trap == 0, "R7 no trap while words free", ovf_trap, 0);
    send_req(27, 77, 9, 1); #1;
    check(ovf_trap == 1, "R7 trap with no vacant word", ovf_trap, 1);
    idle(2); #1;
    check(ntf_valid == 0, "R7 dropped request not offered", ntf_valid, 0);

    // R8 clear by line
    send_clr(70);
    expect_ntf(4, 61, 1, "R8 queue moves forward after clear");
    send_clr(60);
    send_req(28, 72, 9, 0); idle(2);
    send_clr(72);
    expect_ntf(22, 80, 10, "R8 cleared level takes new word");
    send_req(22, 80, 10, 1); idle(2);
    expect_ntf(28, 81, 11, "R8 second match also cleared");
    send_req(28, 81, 11, 1); idle(2);

    // R9 request held while a completion is presented
    expect_ntf(30, 90, 12, "R9 held request accepted later");
    @(negedge clk);
    req_level = 8'd30; req_line = 8'd90; req_sid = 4'd12; req_en = 1'b1; req_valid = 1'b1;
    cmp_valid = 1'b1; cmp_level = 8'd28;
    #1;
    check(req_ready == 0, "R9 ready low during completion", req_ready, 0);
    @(negedge clk);
    cmp_valid = 1'b0;
    #1;
    check(req_ready == 1, "R9 ready back after completion", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    idle(2);

    // R10 back-pressure on the offer
    send_cmp(30);
    ntf_ready = 1'b0;
    expect_ntf(40, 91, 13, "R10 offer taken once after back-pressure");
    send_req(40, 91, 13, 1); #1;
    check(ntf_valid == 1 && ntf_level == 8'd40, "R10 offer present", ntf_level, 40);
    idle(3); #1;
    check(ntf_valid == 1 && ntf_line == 8'd91 && ntf_sid == 4'd13, "R10 offer held",
          {ntf_line, ntf_sid}, {8'd91, 4'd13});
    @(negedge clk);
    ntf_ready = 1'b1;
    idle(3); #1;
    check(ntf_valid == 0, "R10 no repeat after accept", ntf_valid, 0);
    check(exp_q.size() == 0, "R2 all expected offers seen", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule